// File: doc/BRIEF.md
# I2C Register-Access Slave

This block is a slave on a two-wire I2C/SMBus bus that lets an external bus master read and write a small bank of 8-bit registers. A fast system clock oversamples both bus lines. Each line passes through a two-flop synchronizer and a three-sample agreement filter, and the block then watches the filtered lines for START, STOP and clock edges. After START the block collects a 7-bit device address and a direction bit. A write transaction then carries a register index and one data byte. Every address, index and data frame is acknowledged by pulling SDA low through an open-drain output-enable.

Reading takes two bus transactions. The first one carries only the device address and a register index, and the master stops it after the index frame. That index is held in a pointer register, which keeps its value across STOP and across transactions aimed at other devices. A later transaction with the direction bit high then returns one byte from the pointed register. The master, not the slave, drives the acknowledge bit after that byte. The register bank also has a host-side port, so on-chip logic can write and read the same registers.

Top module: `i2c_regbank_slave`

## Requirements
- R1: After reset, sda_oe_o is 0, all 17 registers hold 0x00, and the register pointer is 0, so a read with no earlier pointer write returns register 0.
- R2: The sequence START, device address with direction bit (bit 0 of the first byte) at 0, register index, data byte, STOP writes the data byte into that register. Every byte is sent most significant bit first, and the new value shows on host_rdata_o.
- R3: The slave drives sda_oe_o high during the 9th SCL pulse of a matching device-address frame, of the register-index frame and of the write-data frame, and raises it only while SCL is low.
- R4: A pointer-write transaction (START, device address with direction 0, register index, STOP) followed by START, device address with direction bit 1 makes the slave shift out that register's 8 bits, most significant bit first.
- R5: During the 9th SCL pulse of a read data frame, the slave leaves SDA released (sda_oe_o = 0).
- R6: If the 7 address bits differ from DEV_ADDR, the slave gives no acknowledge, drives nothing and changes no register until the next START.
- R7: Register indices 17 to 255 are acknowledged, writes to them change no register, and reads from them return 0x00.
- R8: The pointer keeps its value across STOP and across transactions whose device address does not match.
- R9: A START that arrives in the middle of a frame restarts device-address reception.
- R10: Pulses of one system-clock cycle on SCL or SDA are filtered out and do not change the bus result.
- R11: Host-port writes (host_we_i, host_addr_i, host_wdata_i) land in the same registers that the bus reads return. When a bus write and a host write hit the same register in the same cycle, the bus write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | High pulls SDA low (open drain) |
| host_we_i | input | 1 | Host register write strobe |
| host_addr_i | input | HAW (5) | Host register index |
| host_wdata_i | input | DW (8) | Host write data |
| host_rdata_o | output | DW (8) | Host read data, 0 for indices above 16 |

## Verification
The bench aims at the out-of-range indices just past the last register. There it checks that the slave still acknowledges, drops the write and returns zero; a design that wrapped the index would instead corrupt a low register. It runs a transaction with a foreign device address and then reads without setting the pointer again. A slave that kept driving, wrote data, or cleared the pointer on STOP would show a stray acknowledge, a changed register or the wrong byte. It also breaks a frame with a repeated START and injects one-cycle spikes on both lines. A design without resynchronization or filtering would lose alignment: it would count extra clocks or see a false START or STOP, and it would store the wrong byte.

// File: rtl/i2c_rb_pkg.sv
package i2c_rb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_REG,
    ST_DATA,
    ST_READ,
    ST_WAIT
  } bus_st_e;
endpackage

// File: rtl/i2c_rb_filter.sv
module i2c_rb_filter #(
  parameter int   NSMP    = 3,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_i,
  output logic flt_o
);
  logic [1:0]      sync_q;
  logic [NSMP-1:0] smp_q;
  logic            flt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= {2{RST_VAL}};
      smp_q  <= {NSMP{RST_VAL}};
      flt_q  <= RST_VAL;
    end else begin
      sync_q <= {sync_q[0], in_i};
      smp_q  <= {smp_q[NSMP-2:0], sync_q[1]};
      // output moves only when the whole window agrees
      if (&smp_q)       flt_q <= 1'b1;
      else if (~|smp_q) flt_q <= 1'b0;
    end
  end

  assign flt_o = flt_q;

  AST_FILT_AGREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(flt_q) |-> ($past(sync_q[1], 2) == flt_q)); // R10
endmodule

// File: rtl/i2c_rb_regs.sv
module i2c_rb_regs #(
  parameter int NREGS = 17,
  parameter int DW    = 8,
  parameter int AW    = 8,
  parameter int HAW   = 5
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           bus_we_i,
  input  logic [AW-1:0]  bus_addr_i,
  input  logic [DW-1:0]  bus_wdata_i,
  output logic [DW-1:0]  bus_rdata_o,
  input  logic           host_we_i,
  input  logic [HAW-1:0] host_addr_i,
  input  logic [DW-1:0]  host_wdata_i,
  output logic [DW-1:0]  host_rdata_o
);
  logic [NREGS-1:0][DW-1:0] regs_q;

  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                     regs_q[i] <= '0;
      else if (bus_we_i && bus_addr_i == AW'(i))       regs_q[i] <= bus_wdata_i;
      else if (host_we_i && host_addr_i == HAW'(i))    regs_q[i] <= host_wdata_i;
    end
  end

  // unmatched indices fall through to zero
  always_comb begin
    bus_rdata_o  = '0;
    host_rdata_o = '0;
    for (int i = 0; i < NREGS; i++) begin
      if (bus_addr_i == AW'(i))   bus_rdata_o  = regs_q[i];
      if (host_addr_i == HAW'(i)) host_rdata_o = regs_q[i];
    end
  end

  AST_OOR_WRITE_DROPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i >= AW'(NREGS) && !host_we_i) |=> $stable(regs_q)); // R7
endmodule

// File: rtl/i2c_rb_link.sv
module i2c_rb_link
  import i2c_rb_pkg::*;
#(
  parameter int         DW       = 8,
  parameter logic [6:0] DEV_ADDR = 7'h3A
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          sda_oe_o,
  output logic          we_o,
  output logic [DW-1:0] ptr_o,
  output logic [DW-1:0] wdata_o
);
  localparam int CW = $clog2(DW);

  bus_st_e       state_q;
  logic          scl_q, sda_q;
  logic [CW-1:0] cnt_q;
  logic          byte_done_q, in_ack_q, rw_q, sda_oe_q, we_q;
  logic [DW-1:0] shreg_q, txreg_q, ptr_q, wdata_q;

  logic start_w, stop_w, scl_rise, scl_fall, busy;

  assign start_w  = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_w   = scl_i & scl_q & ~sda_q & sda_i;
  assign scl_rise = scl_i & ~scl_q;
  assign scl_fall = ~scl_i & scl_q;
  assign busy     = state_q inside {ST_DEV, ST_REG, ST_DATA, ST_READ};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      scl_q       <= 1'b1;
      sda_q       <= 1'b1;
      cnt_q       <= '0;
      byte_done_q <= 1'b0;
      in_ack_q    <= 1'b0;
      rw_q        <= 1'b0;
      sda_oe_q    <= 1'b0;
      we_q        <= 1'b0;
      shreg_q     <= '0;
      txreg_q     <= '0;
      ptr_q       <= '0;
      wdata_q     <= '0;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
      we_q  <= 1'b0;
      if (start_w) begin
        state_q     <= ST_DEV;
        cnt_q       <= '0;
        byte_done_q <= 1'b0;
        in_ack_q    <= 1'b0;
        sda_oe_q    <= 1'b0;
      end else if (stop_w) begin
        state_q     <= ST_IDLE;
        byte_done_q <= 1'b0;
        in_ack_q    <= 1'b0;
        sda_oe_q    <= 1'b0;
      end else if (scl_rise && busy && !in_ack_q) begin
        if (state_q != ST_READ) shreg_q <= {shreg_q[DW-2:0], sda_i};
        cnt_q <= cnt_q + CW'(1);
        if (cnt_q == CW'(DW-1)) byte_done_q <= 1'b1;
      end else if (scl_fall && busy) begin
        if (byte_done_q) begin
          byte_done_q <= 1'b0;
          cnt_q       <= '0;
          case (state_q)
            ST_DEV: begin
              if (shreg_q[DW-1:1] == DEV_ADDR) begin
                rw_q     <= shreg_q[0];
                sda_oe_q <= 1'b1;
                in_ack_q <= 1'b1;
              end else begin
                state_q <= ST_IDLE;  // not addressed: stay silent
              end
            end
            ST_REG: begin
              ptr_q    <= shreg_q;
              sda_oe_q <= 1'b1;
              in_ack_q <= 1'b1;
            end
            ST_DATA: begin
              we_q     <= 1'b1;
              wdata_q  <= shreg_q;
              sda_oe_q <= 1'b1;
              in_ack_q <= 1'b1;
            end
            default: begin     // ST_READ: master owns the ack slot
              sda_oe_q <= 1'b0;
              in_ack_q <= 1'b1;
            end
          endcase
        end else if (in_ack_q) begin
          in_ack_q <= 1'b0;
          case (state_q)
            ST_DEV: begin
              if (rw_q) begin
                state_q  <= ST_READ;
                txreg_q  <= rd_data_i;
                sda_oe_q <= ~rd_data_i[DW-1];
              end else begin
                state_q  <= ST_REG;
                sda_oe_q <= 1'b0;
              end
            end
            ST_REG:  begin state_q <= ST_DATA; sda_oe_q <= 1'b0; end
            default: begin state_q <= ST_WAIT; sda_oe_q <= 1'b0; end
          endcase
        end else if (state_q == ST_READ) begin
          txreg_q  <= {txreg_q[DW-2:0], 1'b0};
          sda_oe_q <= ~txreg_q[DW-2];
        end
      end
    end
  end

  assign sda_oe_o = sda_oe_q;
  assign we_o     = we_q;
  assign ptr_o    = ptr_q;
  assign wdata_o  = wdata_q;

  AST_OE_RISE_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_q) |-> !scl_i); // R3
  AST_READ_ACK_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_READ && in_ack_q) |-> !sda_oe_q); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> !sda_oe_q); // R6
  AST_PTR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q inside {ST_IDLE, ST_WAIT}) |=> $stable(ptr_q)); // R8
endmodule

// File: rtl/i2c_regbank_slave.sv
module i2c_regbank_slave #(
  parameter int         NREGS    = 17,
  parameter int         DW       = 8,
  parameter int         NSMP     = 3,
  parameter logic [6:0] DEV_ADDR = 7'h3A,
  localparam int        HAW      = $clog2(NREGS)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           scl_i,
  input  logic           sda_i,
  output logic           sda_oe_o,
  input  logic           host_we_i,
  input  logic [HAW-1:0] host_addr_i,
  input  logic [DW-1:0]  host_wdata_i,
  output logic [DW-1:0]  host_rdata_o
);
  localparam int NLINE = 2;

  logic [NLINE-1:0] raw_w, flt_w;
  logic             bus_we;
  logic [DW-1:0]    ptr, wdata, rdata;

  assign raw_w = {sda_i, scl_i};

  for (genvar g = 0; g < NLINE; g++) begin : g_flt
    i2c_rb_filter #(.NSMP(NSMP), .RST_VAL(1'b1)) u_flt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .in_i  (raw_w[g]),
      .flt_o (flt_w[g])
    );
  end

  i2c_rb_link #(.DW(DW), .DEV_ADDR(DEV_ADDR)) u_link (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .scl_i    (flt_w[0]),
    .sda_i    (flt_w[1]),
    .rd_data_i(rdata),
    .sda_oe_o (sda_oe_o),
    .we_o     (bus_we),
    .ptr_o    (ptr),
    .wdata_o  (wdata)
  );

  i2c_rb_regs #(.NREGS(NREGS), .DW(DW), .AW(DW), .HAW(HAW)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_we_i    (bus_we),
    .bus_addr_i  (ptr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .host_we_i   (host_we_i),
    .host_addr_i (host_addr_i),
    .host_wdata_i(host_wdata_i),
    .host_rdata_o(host_rdata_o)
  );
endmodule

// File: tb/sim_i2c_regbank_slave.sv
module sim_i2c_regbank_slave;
  localparam int         Q   = 20;
  localparam logic [6:0] DEV = 7'h3A;
  localparam int         NV  = 6;
  // {register index, data}
  localparam logic [15:0] VEC [NV] = '{16'h00A5, 16'h013C, 16'h0780,
                                       16'h0B01, 16'h10FF, 16'h0500};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       m_low = 1'b0;
  logic       glitch = 1'b0;
  logic       sda_oe;
  logic       host_we = 1'b0;
  logic [4:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       sda_bus;
  int         checks = 0;
  int         fails = 0;

  always #2 clk = ~clk;
  assign sda_bus = ~(m_low | sda_oe);

  i2c_regbank_slave #(.DEV_ADDR(DEV)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .host_we_i(host_we), .host_addr_i(host_addr),
    .host_wdata_i(host_wdata), .host_rdata_o(host_rdata)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic i2c_start();
    m_low = 1'b0; step(Q);
    scl_m = 1'b1; step(Q);
    m_low = 1'b1; step(Q);
    scl_m = 1'b0; step(Q);
  endtask

  task automatic i2c_stop();
    m_low = 1'b1; step(Q);
    scl_m = 1'b1; step(Q);
    m_low = 1'b0; step(Q);
  endtask

  task automatic send_bit(input logic b);
    m_low = ~b; step(Q);
    scl_m = 1'b1; step(Q / 2);
    if (glitch) begin
      scl_m = 1'b0; step(1); scl_m = 1'b1; step(2);
      if (b) begin m_low = 1'b1; step(1); m_low = 1'b0; end
    end
    step(Q + Q / 2);
    scl_m = 1'b0; step(Q / 2);
    if (glitch) begin scl_m = 1'b1; step(1); scl_m = 1'b0; end
    step(Q / 2);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    m_low = 1'b0; step(Q);
    scl_m = 1'b1; step(Q);
    ack = ~sda_bus;
    step(Q);
    scl_m = 1'b0; step(Q);
  endtask

  task automatic recv_byte(output logic [7:0] b, output logic slave_in_ack);
    for (int i = 7; i >= 0; i--) begin
      m_low = 1'b0; step(Q);
      scl_m = 1'b1; step(Q);
      b[i] = sda_bus;
      step(Q);
      scl_m = 1'b0; step(Q);
    end
    m_low = 1'b0; step(Q);  // master NACK
    scl_m = 1'b1; step(Q);
    slave_in_ack = sda_oe;
    step(Q);
    scl_m = 1'b0; step(Q);
  endtask

  task automatic bus_write(input logic [7:0] r, input logic [7:0] d,
                           output logic [2:0] acks);
    i2c_start();
    send_byte({DEV, 1'b0}, acks[0]);
    send_byte(r, acks[1]);
    send_byte(d, acks[2]);
    i2c_stop();
  endtask

  task automatic bus_setptr(input logic [7:0] r, output logic [1:0] acks);
    i2c_start();
    send_byte({DEV, 1'b0}, acks[0]);
    send_byte(r, acks[1]);
    i2c_stop();
  endtask

  task automatic bus_read(output logic [7:0] d, output logic ack, output logic sd);
    i2c_start();
    send_byte({DEV, 1'b1}, ack);
    recv_byte(d, sd);
    i2c_stop();
  endtask

  task automatic host_rd(input logic [4:0] a, output logic [7:0] d);
    host_addr = a; step(1);
    d = host_rdata;
  endtask

  task automatic host_wr(input logic [4:0] a, input logic [7:0] d);
    host_addr = a; host_wdata = d; host_we = 1'b1; step(1);
    host_we = 1'b0; step(1);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog act=timeout exp=done");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    logic [2:0] a3;
    logic [1:0] a2;
    logic       a, sd;

    // R1 reset state
    step(5);
    check("R1 oe in reset", int'(sda_oe), 0);
    host_rd(5'd0, d);  check("R1 reg0 reset", d, 8'h00);
    host_rd(5'd16, d); check("R1 reg16 reset", d, 8'h00);
    rst_n = 1'b1; step(5);
    check("R1 oe after reset", int'(sda_oe), 0);

    // R1 pointer resets to 0; R11 host write visible to bus read
    host_wr(5'd0, 8'h5A);
    bus_read(d, a, sd);
    check("R1 read ptr0 ack", int'(a), 1);
    check("R1 R11 read reg0 via reset ptr", d, 8'h5A);

    // table: R2 write, R3 acks, R4 read back, R5 master ack slot
    for (int v = 0; v < NV; v++) begin
      bus_write(VEC[v][15:8], VEC[v][7:0], a3);
      check("R3 write acks", a3, 3'b111);
      host_rd(VEC[v][12:8], d);
      check("R2 host sees bus write", d, VEC[v][7:0]);
      bus_setptr(VEC[v][15:8], a2);
      check("R3 ptr acks", a2, 2'b11);
      bus_read(d, a, sd);
      check("R4 read ack", int'(a), 1);
      check("R4 read data", d, VEC[v][7:0]);
      check("R5 slave off in read ack", int'(sd), 0);
    end

    // R11 host write then bus read
    host_wr(5'd9, 8'hC3);
    bus_setptr(8'd9, a2);
    bus_read(d, a, sd);
    check("R11 bus reads host write", d, 8'hC3);

    // R7 out of range index
    bus_write(8'd17, 8'hEE, a3);
    check("R7 oor write acked", a3, 3'b111);
    host_rd(5'd16, d); check("R7 reg16 untouched", d, 8'hFF);
    host_rd(5'd1, d);  check("R7 reg1 untouched", d, 8'h3C);
    host_rd(5'd0, d);  check("R7 reg0 untouched", d, 8'hA5);
    bus_setptr(8'd17, a2);
    bus_read(d, a, sd);
    check("R7 read idx17 zero", d, 8'h00);
    bus_setptr(8'hFF, a2);
    check("R7 idx255 acked", a2, 2'b11);
    bus_read(d, a, sd);
    check("R7 read idx255 zero", d, 8'h00);

    // R6 foreign address, R8 pointer survives
    bus_setptr(8'd7, a2);
    i2c_start();
    send_byte({DEV ^ 7'h01, 1'b0}, a);
    check("R6 no ack on mismatch", int'(a), 0);
    send_byte(8'd7, a);
    check("R6 no ack index", int'(a), 0);
    send_byte(8'h11, a);
    check("R6 no ack data", int'(a), 0);
    i2c_stop();
    host_rd(5'd7, d); check("R6 reg7 unchanged", d, 8'h80);
    bus_read(d, a, sd);
    check("R8 ptr kept across stop and mismatch", d, 8'h80);

    // R9 START inside a frame
    i2c_start();
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    i2c_start();
    send_byte({DEV, 1'b0}, a3[0]);
    send_byte(8'd2, a3[1]);
    send_byte(8'h77, a3[2]);
    i2c_stop();
    check("R9 acks after restart", a3, 3'b111);
    host_rd(5'd2, d); check("R9 write after restart", d, 8'h77);

    // R10 one-cycle spikes on SCL and SDA
    glitch = 1'b1;
    bus_write(8'd4, 8'hD2, a3);
    glitch = 1'b0;
    check("R10 acks with spikes", a3, 3'b111);
    host_rd(5'd4, d); check("R10 data with spikes", d, 8'hD2);
    check("R10 bus idle", int'(sda_oe), 0);

    finish_run();
  end
endmodule